// File: doc/BRIEF.md
# Indirect Register Access Sequencer

This block sits on the host side of a management bus. A device that has many internal register sets but answers on only one bus address exposes a small window of two registers: a command register at window offset 0 and a data register at window offset 1. Reaching a register behind that window takes several bus accesses, and each one has to wait for the device's busy flag. The sequencer takes one request and issues the whole chain over a generic register read/write master port. A request carries a direction, a target bus address, an inner device number, a register offset and, for writes, 16 bits of data. The sequencer then reports the outcome with a one-cycle completion pulse.

Busy waits read the command register, and a wait succeeds once bit 15 reads as zero. Between polls the sequencer waits a parameterised number of cycles. After a parameterised number of unsuccessful polls it gives up with a timeout. When the request's target bus address is zero, the device is taken to decode bus addresses itself. The sequencer then performs one direct access, with the inner device number placed on the bus address lines.

Top module: `indirect_access_seq`

## Requirements
- R1: After reset `reqReady` is 1, `done` is 0 and `busReq` is 0.
- R2: A read with a nonzero target address runs four steps, all at the target bus address. First it polls window offset 0 until the busy flag clears. Then it writes the command word to offset 0, polls again, and reads offset 1. On completion `rdData` equals that read's 16-bit data and `errCode` is 0 (ok).
- R3: A write with a nonzero target address also runs four steps at the target bus address: a poll, a write of `reqWdata` to offset 1, a write of the command word to offset 0, and a second poll. It completes with `errCode` 0 once that poll sees the busy flag clear.
- R4: The command word is laid out as follows:
  - bit 15 is set (busy), bits 14:13 are zero and bit 12 is set;
  - bits 11:10 hold the opcode, 2 for read and 1 for write;
  - bits 9:5 hold the device number and bits 4:0 the register offset.
- R5: Two consecutive polls within one busy wait start at least `POLL_GAP` cycles apart.
- R6: A busy wait makes at most `POLL_LIMIT` polls. If none of them succeeds, the request completes with `errCode` 1 (timeout) and no further access is made.
- R7: A poll whose lower access returns an error counts as an unsuccessful poll, whatever data came back, and the wait goes on polling.
- R8: An error on any non-poll lower access ends the request at once with `errCode` 2 (bus error), and no further access is issued.
- R9: With a target bus address of 0, a request is a single access: bus address = device number, register = register offset, with the request's direction and write data. A direct read returns its data in `rdData`.
- R10: `done` is high for exactly one cycle per request. `reqValid` has no effect while `reqReady` is low.
- R11: Once raised, `busReq` stays high with unchanged address, register, direction and write data until the cycle in which `busAck` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken only while reqReady is high |
| reqReady | output | 1 | Sequencer idle and able to take a request |
| reqWrite | input | 1 | 1 = write request, 0 = read request |
| reqBusAddr | input | 5 | Target bus address; 0 selects the direct path |
| reqDev | input | 5 | Inner device number |
| reqReg | input | 5 | Register offset inside the device |
| reqWdata | input | 16 | Write data |
| done | output | 1 | One-cycle completion pulse |
| errCode | output | 2 | Outcome, valid with done: 0 ok, 1 timeout, 2 bus error |
| rdData | output | 16 | Read result, valid with done after an ok read |
| busReq | output | 1 | Lower access request, held until busAck |
| busWrite | output | 1 | Lower access direction |
| busAddr | output | 5 | Lower access bus address |
| busReg | output | 5 | Lower access register offset |
| busWdata | output | 16 | Lower access write data |
| busAck | input | 1 | Lower access complete, one cycle |
| busErr | input | 1 | Lower access failed, valid with busAck |
| busRdata | input | 16 | Lower access read data, valid with busAck |

## Verification
The bench builds the block with `POLL_LIMIT` = 5 and `POLL_GAP` = 4 instead of the defaults of 100 polls and 1000 cycles. With these values the timeout path finishes in a few dozen cycles, so exhausting the retry limit can be exercised directly. The smaller gap also keeps the spacing between polls short enough to measure from the bench's access log. A responder model with a programmable busy count, a programmable number of failing polls, a fault injected at a chosen access and a variable acknowledge latency covers the retry, abort and hold-until-acknowledge cases.

// File: rtl/indacc_pkg.sv
package indacc_pkg;
  localparam int WORD_W   = 16;
  localparam int FIELD_W  = 5;
  localparam int BUSY_BIT = 15;
  localparam logic [FIELD_W-1:0] WIN_CMD  = 5'd0;
  localparam logic [FIELD_W-1:0] WIN_DATA = 5'd1;
  localparam logic [1:0] OPC_READ  = 2'd2;
  localparam logic [1:0] OPC_WRITE = 2'd1;

  typedef enum logic [1:0] {
    ERR_OK      = 2'd0,
    ERR_TIMEOUT = 2'd1,
    ERR_BUS     = 2'd2
  } errCode_e;

  typedef enum logic [2:0] {
    ACC_POLL,
    ACC_CMD,
    ACC_DATA_WR,
    ACC_DATA_RD,
    ACC_DIRECT
  } acc_e;

  typedef struct packed {
    logic latchReq;
    logic pollClr;
    logic pollInc;
    logic gapLoad;
    logic rdCapture;
    acc_e acc;
  } ctrlStrobe_t;
endpackage

// File: rtl/indacc_dp.sv
module indacc_dp
  import indacc_pkg::*;
#(
  parameter int POLL_LIMIT = 100,
  parameter int POLL_GAP   = 1000
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strb,
  input  logic               reqWrite,
  input  logic [FIELD_W-1:0] reqBusAddr,
  input  logic [FIELD_W-1:0] reqDev,
  input  logic [FIELD_W-1:0] reqReg,
  input  logic [WORD_W-1:0]  reqWdata,
  input  logic [WORD_W-1:0]  busRdata,
  output logic [FIELD_W-1:0] busAddr,
  output logic [FIELD_W-1:0] busReg,
  output logic               busWrite,
  output logic [WORD_W-1:0]  busWdata,
  output logic [WORD_W-1:0]  rdData,
  output logic               opWrite,
  output logic               pollMax,
  output logic               gapZero
);
  localparam int PCW = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam int GW  = $clog2(POLL_GAP + 1);

  logic               wrQ;
  logic [FIELD_W-1:0] addrQ, devQ, regQ;
  logic [WORD_W-1:0]  wdQ, rdQ;
  logic [PCW-1:0]     pollCnt;
  logic [GW-1:0]      gapCnt;
  logic [WORD_W-1:0]  cmdWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrQ <= 1'b0; addrQ <= '0; devQ <= '0; regQ <= '0;
      wdQ <= '0; rdQ <= '0; pollCnt <= '0; gapCnt <= '0;
    end else begin
      if (strb.latchReq) begin
        wrQ <= reqWrite; addrQ <= reqBusAddr; devQ <= reqDev;
        regQ <= reqReg; wdQ <= reqWdata;
      end
      if (strb.pollClr)      pollCnt <= '0;
      else if (strb.pollInc) pollCnt <= pollCnt + 1'b1;
      if (strb.gapLoad)      gapCnt <= GW'(POLL_GAP);
      else if (gapCnt != '0) gapCnt <= gapCnt - 1'b1;
      if (strb.rdCapture)    rdQ <= busRdata;
    end
  end

  assign cmdWord = {1'b1, 2'b00, 1'b1, (wrQ ? OPC_WRITE : OPC_READ), devQ, regQ};
  assign pollMax = (pollCnt == PCW'(POLL_LIMIT - 1));
  assign gapZero = (gapCnt == '0);
  assign opWrite = wrQ;
  assign rdData  = rdQ;

  always_comb begin
    busAddr  = addrQ;
    busReg   = WIN_CMD;
    busWrite = 1'b0;
    busWdata = '0;
    unique case (strb.acc)
      ACC_CMD:     begin busWrite = 1'b1; busWdata = cmdWord; end
      ACC_DATA_WR: begin busReg = WIN_DATA; busWrite = 1'b1; busWdata = wdQ; end
      ACC_DATA_RD: busReg = WIN_DATA;
      ACC_DIRECT:  begin
        busAddr = devQ; busReg = regQ; busWrite = wrQ;
        busWdata = wrQ ? wdQ : '0;
      end
      default: ;
    endcase
  end

  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    strb.pollInc |-> (pollCnt < PCW'(POLL_LIMIT - 1))); // R6
endmodule

// File: rtl/indacc_ctrl.sv
module indacc_ctrl
  import indacc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        directReq,
  input  logic        opWrite,
  input  logic        pollMax,
  input  logic        gapZero,
  input  logic        busAck,
  input  logic        busErr,
  input  logic        busyFlag,
  output ctrlStrobe_t strb,
  output logic        reqReady,
  output logic        busReq,
  output logic        done,
  output logic [1:0]  errCode
);
  typedef enum logic [2:0] {
    S_IDLE, S_POLL, S_GAP, S_WDATA, S_CMD, S_RDATA, S_DIRECT, S_DONE
  } state_e;

  state_e   st, stNext;
  logic     second, secondNext;
  errCode_e errQ, errNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st <= S_IDLE; second <= 1'b0; errQ <= ERR_OK;
    end else begin
      st <= stNext; second <= secondNext; errQ <= errNext;
    end
  end

  always_comb begin
    stNext = st; secondNext = second; errNext = errQ;
    strb = '0; strb.acc = ACC_POLL;
    busReq = 1'b0; reqReady = 1'b0; done = 1'b0;
    unique case (st)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strb.latchReq = 1'b1; strb.pollClr = 1'b1;
          secondNext = 1'b0; errNext = ERR_OK;
          stNext = directReq ? S_DIRECT : S_POLL;
        end
      end
      S_POLL: begin
        busReq = 1'b1; strb.acc = ACC_POLL;
        if (busAck) begin
          if (!busErr && !busyFlag) begin
            strb.pollClr = 1'b1;
            if (!second) stNext = opWrite ? S_WDATA : S_CMD;
            else         stNext = opWrite ? S_DONE : S_RDATA;
          end else if (pollMax) begin
            errNext = ERR_TIMEOUT; stNext = S_DONE;
          end else begin
            strb.pollInc = 1'b1; strb.gapLoad = 1'b1; stNext = S_GAP;
          end
        end
      end
      S_GAP: if (gapZero) stNext = S_POLL;
      S_WDATA: begin
        busReq = 1'b1; strb.acc = ACC_DATA_WR;
        if (busAck) begin
          if (busErr) begin errNext = ERR_BUS; stNext = S_DONE; end
          else stNext = S_CMD;
        end
      end
      S_CMD: begin
        busReq = 1'b1; strb.acc = ACC_CMD;
        if (busAck) begin
          if (busErr) begin errNext = ERR_BUS; stNext = S_DONE; end
          else begin secondNext = 1'b1; stNext = S_POLL; end
        end
      end
      S_RDATA: begin
        busReq = 1'b1; strb.acc = ACC_DATA_RD;
        if (busAck) begin
          if (busErr) errNext = ERR_BUS;
          else strb.rdCapture = 1'b1;
          stNext = S_DONE;
        end
      end
      S_DIRECT: begin
        busReq = 1'b1; strb.acc = ACC_DIRECT;
        if (busAck) begin
          if (busErr) errNext = ERR_BUS;
          else strb.rdCapture = !opWrite;
          stNext = S_DONE;
        end
      end
      S_DONE: begin
        done = 1'b1; stNext = S_IDLE;
      end
      default: stNext = S_IDLE;
    endcase
  end

  assign errCode = errQ;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
  AST_BUS_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_DONE && errQ == ERR_BUS) |-> $past(busAck && busErr)); // R8
  AST_GAP_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (st == S_POLL && $past(st) == S_GAP) |-> $past(gapZero)); // R5
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck) |=> (busReq && $stable(strb.acc))); // R11
endmodule

// File: rtl/indirect_access_seq.sv
module indirect_access_seq
  import indacc_pkg::*;
#(
  parameter int POLL_LIMIT = 100,
  parameter int POLL_GAP   = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        reqWrite,
  input  logic [4:0]  reqBusAddr,
  input  logic [4:0]  reqDev,
  input  logic [4:0]  reqReg,
  input  logic [15:0] reqWdata,
  output logic        done,
  output logic [1:0]  errCode,
  output logic [15:0] rdData,
  output logic        busReq,
  output logic        busWrite,
  output logic [4:0]  busAddr,
  output logic [4:0]  busReg,
  output logic [15:0] busWdata,
  input  logic        busAck,
  input  logic        busErr,
  input  logic [15:0] busRdata
);
  ctrlStrobe_t strb;
  logic opWrite, pollMax, gapZero;

  indacc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid),
    .directReq(reqBusAddr == '0), .opWrite(opWrite),
    .pollMax(pollMax), .gapZero(gapZero), .busAck(busAck), .busErr(busErr),
    .busyFlag(busRdata[BUSY_BIT]), .strb(strb), .reqReady(reqReady),
    .busReq(busReq), .done(done), .errCode(errCode)
  );

  indacc_dp #(.POLL_LIMIT(POLL_LIMIT), .POLL_GAP(POLL_GAP)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqWrite(reqWrite),
    .reqBusAddr(reqBusAddr), .reqDev(reqDev), .reqReg(reqReg),
    .reqWdata(reqWdata), .busRdata(busRdata), .busAddr(busAddr),
    .busReg(busReg), .busWrite(busWrite), .busWdata(busWdata),
    .rdData(rdData), .opWrite(opWrite), .pollMax(pollMax), .gapZero(gapZero)
  );
endmodule

// File: tb/tb_indirect_access_seq.sv
module tb_indirect_access_seq;
  localparam int CLK_PERIOD = 10;
  localparam int P_LIMIT = 5;
  localparam int P_GAP   = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [4:0] reqBusAddr = '0, reqDev = '0, reqReg = '0;
  logic [15:0] reqWdata = '0;
  logic reqReady, done, busReq, busWrite;
  logic [1:0] errCode;
  logic [15:0] rdData, busWdata;
  logic [4:0] busAddr, busReg;
  logic busAck = 1'b0, busErr = 1'b0;
  logic [15:0] busRdata = '0;

  indirect_access_seq #(.POLL_LIMIT(P_LIMIT), .POLL_GAP(P_GAP)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // responder model state
  int busyLeft = 0, cmdBusy = 0, pollErrLeft = 0, failAt = -1, ackDelay = 0, accN = 0;
  logic [15:0] slaveData = 16'hBEEF;
  logic        logW [32];
  logic [4:0]  logA [32];
  logic [4:0]  logR [32];
  logic [15:0] logD [32];
  int          logT [32];
  int          doneCnt = 0;
  logic [1:0]  gotErr;
  logic [15:0] gotRd;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (done) doneCnt++;

  initial begin
    forever begin
      @(negedge clk);
      if (busAck) begin
        busAck = 1'b0; busErr = 1'b0;
      end else if (busReq) begin
        logic w; logic [4:0] a, r; logic [15:0] d; bit e;
        w = busWrite; a = busAddr; r = busReg; d = busWdata;
        for (int k = 0; k < ackDelay; k++) begin
          @(negedge clk);
          check(busReq && busWrite == w && busAddr == a && busReg == r && busWdata == d,
                "R11 request held until ack", {busReq, busAddr, busReg}, {1'b1, a, r});
        end
        e = (accN == failAt);
        busRdata = slaveData;
        if (!w && r == 5'd0 && pollErrLeft > 0) begin
          e = 1'b1; pollErrLeft--; busRdata = 16'h0000;
        end else if (!w && r == 5'd0 && a != 5'd0 && reqBusAddr != 5'd0) begin
          busRdata = (busyLeft > 0) ? 16'h8000 : 16'h0000;
          if (busyLeft > 0) busyLeft--;
        end
        if (w && r == 5'd0) busyLeft = cmdBusy;
        if (accN < 32) begin
          logW[accN] = w; logA[accN] = a; logR[accN] = r; logD[accN] = d; logT[accN] = cyc;
        end
        accN++;
        busErr = e; busAck = 1'b1;
      end
    end
  end

  task automatic setup(input int busy, input int cbusy, input int perr, input int fAt, input int dly);
    busyLeft = busy; cmdBusy = cbusy; pollErrLeft = perr; failAt = fAt; ackDelay = dly;
    accN = 0; doneCnt = 0;
  endtask

  task automatic issue(input bit w, input logic [4:0] ba, input logic [4:0] dv,
                       input logic [4:0] rg, input logic [15:0] wd, input bit inject);
    int t = 0;
    @(negedge clk);
    check(reqReady == 1'b1, "R10 ready before request", reqReady, 1);
    reqWrite = w; reqBusAddr = ba; reqDev = dv; reqReg = rg; reqWdata = wd; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    if (inject) begin
      @(negedge clk);
      reqWrite = 1'b1; reqDev = 5'd30; reqReg = 5'd30; reqValid = 1'b1;
      repeat (3) @(negedge clk);
      reqValid = 1'b0; reqWrite = w; reqDev = dv; reqReg = rg;
    end
    while (!done && t < 3000) begin @(negedge clk); t++; end
    gotErr = errCode; gotRd = rdData;
    @(negedge clk);
    check(done == 1'b0, "R10 done lasts one cycle", done, 0);
  endtask

  task automatic chk_acc(input int i, input bit w, input logic [4:0] a, input logic [4:0] r,
                         input logic [15:0] d, input string tag);
    check(logW[i] == w && logA[i] == a && logR[i] == r, tag, {logW[i], logA[i], logR[i]}, {w, a, r});
    if (w) check(logD[i] == d, tag, logD[i], d);
  endtask

  task automatic t_reset();
    check(reqReady == 1'b1 && done == 1'b0 && busReq == 1'b0, "R1 reset state",
          {reqReady, done, busReq}, 3'b100);
  endtask

  task automatic t_read();
    setup(2, 0, 0, -1, 0);
    slaveData = 16'hBEEF;
    issue(1'b0, 5'd7, 5'd3, 5'h11, 16'h0, 1'b0);
    check(accN == 6, "R2 read access count", accN, 6);
    for (int i = 0; i < 3; i++) chk_acc(i, 1'b0, 5'd7, 5'd0, 16'h0, "R2 first wait poll");
    chk_acc(3, 1'b1, 5'd7, 5'd0, 16'h9871, "R4 read command word");
    chk_acc(4, 1'b0, 5'd7, 5'd0, 16'h0, "R2 second wait poll");
    chk_acc(5, 1'b0, 5'd7, 5'd1, 16'h0, "R2 data register read");
    check(gotErr == 2'd0 && gotRd == 16'hBEEF, "R2 read result", gotRd, 16'hBEEF);
    check(logT[1] - logT[0] >= P_GAP, "R5 poll spacing", logT[1] - logT[0], P_GAP);
    check(logT[2] - logT[1] >= P_GAP, "R5 poll spacing", logT[2] - logT[1], P_GAP);
  endtask

  task automatic t_write();
    setup(0, 1, 0, -1, 0);
    issue(1'b1, 5'd9, 5'h12, 5'h16, 16'h1234, 1'b0);
    check(accN == 5, "R3 write access count", accN, 5);
    chk_acc(0, 1'b0, 5'd9, 5'd0, 16'h0, "R3 first poll");
    chk_acc(1, 1'b1, 5'd9, 5'd1, 16'h1234, "R3 data write");
    chk_acc(2, 1'b1, 5'd9, 5'd0, 16'h9656, "R4 write command word");
    chk_acc(3, 1'b0, 5'd9, 5'd0, 16'h0, "R3 second wait busy poll");
    chk_acc(4, 1'b0, 5'd9, 5'd0, 16'h0, "R3 second wait clear poll");
    check(gotErr == 2'd0, "R3 write ok", gotErr, 0);
  endtask

  task automatic t_timeout();
    setup(1000, 0, 0, -1, 0);
    issue(1'b0, 5'd7, 5'd1, 5'd2, 16'h0, 1'b0);
    repeat (20) @(negedge clk);
    check(accN == P_LIMIT, "R6 poll count at timeout", accN, P_LIMIT);
    check(gotErr == 2'd1, "R6 timeout code", gotErr, 1);
  endtask

  task automatic t_poll_err();
    setup(0, 0, 2, -1, 0);
    slaveData = 16'h5A5A;
    issue(1'b0, 5'd7, 5'd4, 5'd5, 16'h0, 1'b0);
    check(accN == 6, "R7 errored polls retried", accN, 6);
    check(gotErr == 2'd0 && gotRd == 16'h5A5A, "R7 read completes", gotRd, 16'h5A5A);
  endtask

  task automatic t_bus_err();
    setup(0, 0, 0, 1, 0);
    issue(1'b0, 5'd7, 5'd4, 5'd5, 16'h0, 1'b0);
    repeat (10) @(negedge clk);
    check(accN == 2, "R8 abort after command write error", accN, 2);
    check(gotErr == 2'd2, "R8 bus error code", gotErr, 2);
    setup(0, 0, 0, 1, 0);
    issue(1'b1, 5'd7, 5'd4, 5'd5, 16'hAAAA, 1'b0);
    repeat (10) @(negedge clk);
    check(accN == 2, "R8 abort after data write error", accN, 2);
    check(gotErr == 2'd2, "R8 bus error code on write", gotErr, 2);
  endtask

  task automatic t_direct();
    setup(0, 0, 0, -1, 0);
    slaveData = 16'hC0DE;
    issue(1'b0, 5'd0, 5'd9, 5'd2, 16'h0, 1'b0);
    check(accN == 1, "R9 direct read single access", accN, 1);
    chk_acc(0, 1'b0, 5'd9, 5'd2, 16'h0, "R9 direct read fields");
    check(gotRd == 16'hC0DE && gotErr == 2'd0, "R9 direct read data", gotRd, 16'hC0DE);
    setup(0, 0, 0, -1, 0);
    issue(1'b1, 5'd0, 5'd17, 5'd6, 16'h7E57, 1'b0);
    check(accN == 1, "R9 direct write single access", accN, 1);
    chk_acc(0, 1'b1, 5'd17, 5'd6, 16'h7E57, "R9 direct write fields");
  endtask

  task automatic t_ignore_busy();
    setup(0, 0, 0, -1, 0);
    slaveData = 16'h0F0F;
    issue(1'b0, 5'd7, 5'd2, 5'd3, 16'h0, 1'b1);
    repeat (40) @(negedge clk);
    check(accN == 4, "R10 request while busy ignored", accN, 4);
    check(doneCnt == 1, "R10 single completion", doneCnt, 1);
    chk_acc(1, 1'b1, 5'd7, 5'd0, 16'h9843, "R10 command unaffected");
  endtask

  task automatic t_slow();
    setup(1, 0, 0, -1, 3);
    slaveData = 16'h1357;
    issue(1'b0, 5'd7, 5'd2, 5'd3, 16'h0, 1'b0);
    check(accN == 5 && gotRd == 16'h1357, "R11 slow responder read", gotRd, 16'h1357);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_read();
    t_write();
    t_timeout();
    t_poll_err();
    t_bus_err();
    t_direct();
    t_ignore_busy();
    t_slow();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule